// File: doc/BRIEF.md
# SPI Master Byte Shift Engine

This block is the serial core of an SPI master that moves 8-bit words. A burst is started with a single-cycle start request. The burst has a programmed length in bytes. A second count says how many of those bytes are taken from the transmit stream. Every byte past that count is sent as 0x00. Each received byte is pushed onto an output stream, unless the discard option is on. SCK timing is not generated inside the block. A separate divider supplies a one-cycle tick, and each tick moves SCK by one half period.

Clock polarity, clock phase, bit order, chip-select selection, chip-select polarity and manual chip-select level are plain configuration inputs. Software must hold them steady while a burst runs. A global enable and a master-mode input both gate all bus activity. A synchronous soft reset aborts whatever is in flight.

The transmit stream is valid/ready. The engine raises `tx_ready` only when it is waiting to start a byte that needs transmit data. If `tx_valid` is low at that point, the engine waits with SCK at rest. The receive stream is valid/ready with a single holding register. A byte stays on `rx_data` until `rx_ready` accepts it. The next byte does not begin while that register is still full, so received data is never lost.

Top module: `spi_xfer_engine`

## Requirements
- R1: Outside a burst, `sck` equals `cfg_cpol`, and `sck` only changes on a gated `sck_tick`.
- R2: With `cfg_cpha`=0, MISO is sampled on the leading SCK edge and MOSI changes on the trailing edge. With `cfg_cpha`=1 this is reversed. Every byte takes exactly 16 SCK transitions.
- R3: `cfg_lsb_first`=1 shifts bit 0 first, on both MOSI and MISO. When it is 0, bit 7 goes first.
- R4: The first min(`tx_len`, `burst_len`) bytes each consume one transmit handshake. The remaining bytes are sent as 0x00 and consume none.
- R5: With `cfg_rx_discard`=1, no received byte reaches the receive stream.
- R6: When a byte needs transmit data and `tx_valid` is low, the engine waits with `busy` high, `tx_ready` high and SCK at rest.
- R7: A new byte does not start while the receive holding register is full and discard is off.
- R8: `busy` rises after an accepted start and falls on the cycle `done` pulses. `done` is a one-cycle pulse raised after the last bit of the last byte is sampled. A burst length of 0 pulses `done` with no SCK activity.
- R9: Automatic chip select (`cfg_cs_manual`=0): line `cfg_cs_sel` is at the active level while `busy` is high. Every other line stays at the inactive level. The active level is high when `cfg_cs_pol`=1 and low when it is 0.
- R10: Manual chip select: line `cfg_cs_sel` follows `cfg_cs_level`. Every other line stays inactive.
- R11: While `cfg_enable` or `cfg_master` is low, `start` is ignored and ticks have no effect.
- R12: `cfg_soft_rst` ends a burst at once, with no `done` pulse, and leaves the engine idle and ready for a new start.
- R13: While `rx_valid` is high and `rx_ready` is low, `rx_valid` and `rx_data` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_enable | input | 1 | Global bus enable |
| cfg_master | input | 1 | Master mode select; must be 1 for activity |
| cfg_soft_rst | input | 1 | Synchronous abort and clear |
| cfg_cpol | input | 1 | SCK rest level |
| cfg_cpha | input | 1 | Clock phase |
| cfg_lsb_first | input | 1 | 1 = least significant bit first |
| cfg_cs_pol | input | 1 | 1 = chip select active high |
| cfg_cs_sel | input | SEL_W (2) | Index of the chip select in use |
| cfg_cs_manual | input | 1 | 1 = chip select driven from cfg_cs_level |
| cfg_cs_level | input | 1 | Raw level of the selected line in manual mode |
| cfg_rx_discard | input | 1 | 1 = drop received bytes |
| burst_len | input | CNT_W (24) | Bytes in the burst |
| tx_len | input | CNT_W (24) | Bytes taken from the transmit stream |
| start | input | 1 | Start request, one cycle |
| busy | output | 1 | Burst in progress |
| done | output | 1 | Burst complete pulse |
| sck_tick | input | 1 | Half-period enable from the divider |
| tx_valid | input | 1 | Transmit byte available |
| tx_ready | output | 1 | Transmit byte accepted |
| tx_data | input | 8 | Transmit byte |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Received byte accepted |
| rx_data | output | 8 | Received byte |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_o | output | NUM_CS (4) | Chip select lines |

## Verification
The hardest state to reach is a stall inside a burst that was already running. One case is the receive register left full between two bytes. The other is an empty transmit stream at the start of a byte. Both are checked for a frozen SCK and an asserted chip select. To reach them, the bench holds `rx_ready` low or keeps its transmit source quiet. It then runs the tick long enough for a byte to have finished. It counts SCK transitions before releasing the stream. MISO is looped back inverted from MOSI, so any error in bit order or capture edge shows up in the received bytes.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam int BYTE_W = 8;
  localparam int HALF_W = $clog2(2 * BYTE_W);

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_FETCH,
    SEQ_SHIFT
  } seq_state_e;

  // Bit that leaves the shift register next.
  function automatic logic pick_bit(input logic [BYTE_W-1:0] v, input logic lsb);
    return lsb ? v[0] : v[BYTE_W-1];
  endfunction

  // Shift register after one bit has left.
  function automatic logic [BYTE_W-1:0] advance(input logic [BYTE_W-1:0] v, input logic lsb);
    return lsb ? {1'b0, v[BYTE_W-1:1]} : {v[BYTE_W-2:0], 1'b0};
  endfunction
endpackage

// File: rtl/spi_byte_seq.sv
module spi_byte_seq
  import spi_eng_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              run_ok,
  input  logic              start,
  input  logic [CNT_W-1:0]  burst_len,
  input  logic [CNT_W-1:0]  tx_len,
  input  logic              tx_valid,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              rx_free,
  input  logic              byte_end,
  output logic              tx_ready,
  output logic              load,
  output logic [BYTE_W-1:0] load_data,
  output logic              busy,
  output logic              done
);
  seq_state_e       state_q;
  logic [CNT_W-1:0] idx_q, burst_q, txlen_q;
  logic [CNT_W-1:0] idx_nx;
  logic             need_tx, fetch_ok;

  assign need_tx   = (idx_q < txlen_q);
  assign fetch_ok  = (state_q == SEQ_FETCH) && run_ok && rx_free;
  assign tx_ready  = fetch_ok && need_tx;
  assign load      = fetch_ok && (!need_tx || tx_valid);
  assign load_data = need_tx ? tx_data : '0;
  assign idx_nx    = idx_q + CNT_W'(1);
  assign busy      = (state_q != SEQ_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
      burst_q <= '0;
      txlen_q <= '0;
      done    <= 1'b0;
    end else if (soft_rst) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        SEQ_IDLE: begin
          if (start && run_ok) begin
            burst_q <= burst_len;
            txlen_q <= tx_len;
            idx_q   <= '0;
            if (burst_len == '0) done <= 1'b1;
            else                 state_q <= SEQ_FETCH;
          end
        end
        SEQ_FETCH: begin
          if (load) state_q <= SEQ_SHIFT;
        end
        SEQ_SHIFT: begin
          if (byte_end) begin
            idx_q <= idx_nx;
            if (idx_nx == burst_q) begin
              done    <= 1'b1;
              state_q <= SEQ_IDLE;
            end else begin
              state_q <= SEQ_FETCH;
            end
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_bit_shifter.sv
module spi_bit_shifter
  import spi_eng_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              tick,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_data,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              lsb_first,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              byte_end,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam logic [HALF_W-1:0] LAST_HALF = HALF_W'(2 * BYTE_W - 1);

  logic              active_q, phase_q;
  logic [HALF_W-1:0] half_q;
  logic [BYTE_W-1:0] tx_sh_q, rx_sh_q, rx_next;
  logic              leading, sample_now;

  assign leading    = ~half_q[0];
  assign sample_now = leading ^ cpha;
  assign rx_next    = lsb_first ? {miso, rx_sh_q[BYTE_W-1:1]} : {rx_sh_q[BYTE_W-2:0], miso};
  assign sck        = cpol ^ phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      phase_q  <= 1'b0;
      half_q   <= '0;
      tx_sh_q  <= '0;
      rx_sh_q  <= '0;
      rx_byte  <= '0;
      mosi     <= 1'b0;
      byte_end <= 1'b0;
    end else if (soft_rst) begin
      active_q <= 1'b0;
      phase_q  <= 1'b0;
      half_q   <= '0;
      mosi     <= 1'b0;
      byte_end <= 1'b0;
    end else begin
      byte_end <= 1'b0;
      if (load) begin
        active_q <= 1'b1;
        phase_q  <= 1'b0;
        half_q   <= '0;
        rx_sh_q  <= '0;
        if (!cpha) begin
          mosi    <= pick_bit(load_data, lsb_first);
          tx_sh_q <= advance(load_data, lsb_first);
        end else begin
          tx_sh_q <= load_data;
        end
      end else if (tick && active_q) begin
        phase_q <= ~phase_q;
        half_q  <= half_q + HALF_W'(1);
        if (sample_now) begin
          rx_sh_q <= rx_next;
        end else begin
          mosi    <= pick_bit(tx_sh_q, lsb_first);
          tx_sh_q <= advance(tx_sh_q, lsb_first);
        end
        if (half_q == LAST_HALF) begin
          active_q <= 1'b0;
          byte_end <= 1'b1;
          rx_byte  <= sample_now ? rx_next : rx_sh_q;
        end
      end
    end
  end
endmodule

// File: rtl/spi_cs_drive.sv
module spi_cs_drive #(
  parameter int NUM_CS = 4,
  parameter int SEL_W  = 2
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic              pol,
  input  logic              manual,
  input  logic              level,
  input  logic              busy,
  output logic [NUM_CS-1:0] cs_o
);
  logic picked_level;

  assign picked_level = manual ? level : (busy ? pol : ~pol);

  for (genvar g = 0; g < NUM_CS; g++) begin : g_line
    assign cs_o[g] = (sel == SEL_W'(g)) ? picked_level : ~pol;
  end
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
  import spi_eng_pkg::*;
#(
  parameter  int CNT_W  = 24,
  parameter  int NUM_CS = 4,
  localparam int SEL_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic              cfg_master,
  input  logic              cfg_soft_rst,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_lsb_first,
  input  logic              cfg_cs_pol,
  input  logic [SEL_W-1:0]  cfg_cs_sel,
  input  logic              cfg_cs_manual,
  input  logic              cfg_cs_level,
  input  logic              cfg_rx_discard,
  input  logic [CNT_W-1:0]  burst_len,
  input  logic [CNT_W-1:0]  tx_len,
  input  logic              start,
  output logic              busy,
  output logic              done,
  input  logic              sck_tick,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [BYTE_W-1:0] rx_data,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] cs_o
);
  logic              run_ok, tick_g, rx_free;
  logic              load, byte_end;
  logic [BYTE_W-1:0] load_data, rx_byte;

  assign run_ok  = cfg_enable & cfg_master;
  assign tick_g  = sck_tick & run_ok;
  assign rx_free = ~rx_valid | cfg_rx_discard;

  spi_byte_seq #(.CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (cfg_soft_rst),
    .run_ok    (run_ok),
    .start     (start),
    .burst_len (burst_len),
    .tx_len    (tx_len),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .rx_free   (rx_free),
    .byte_end  (byte_end),
    .tx_ready  (tx_ready),
    .load      (load),
    .load_data (load_data),
    .busy      (busy),
    .done      (done)
  );

  spi_bit_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (cfg_soft_rst),
    .tick      (tick_g),
    .load      (load),
    .load_data (load_data),
    .cpol      (cfg_cpol),
    .cpha      (cfg_cpha),
    .lsb_first (cfg_lsb_first),
    .miso      (miso),
    .sck       (sck),
    .mosi      (mosi),
    .byte_end  (byte_end),
    .rx_byte   (rx_byte)
  );

  spi_cs_drive #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) u_cs (
    .sel    (cfg_cs_sel),
    .pol    (cfg_cs_pol),
    .manual (cfg_cs_manual),
    .level  (cfg_cs_level),
    .busy   (busy),
    .cs_o   (cs_o)
  );

  // Single-entry receive holding register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else if (cfg_soft_rst) begin
      rx_valid <= 1'b0;
    end else if (byte_end && !cfg_rx_discard) begin
      rx_valid <= 1'b1;
      rx_data  <= rx_byte;
    end else if (rx_valid && rx_ready) begin
      rx_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_xfer_engine_chk.sv
module spi_xfer_engine_chk #(
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_rst,
  input logic              enable,
  input logic              master,
  input logic              cpol,
  input logic              cs_pol,
  input logic              cs_manual,
  input logic              rx_discard,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              tx_ready,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [7:0]        rx_data,
  input logic              sck,
  input logic [NUM_CS-1:0] cs_o
);
  AST_SCK_REST: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sck == cpol)); // R1
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8
  AST_TX_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> busy); // R4
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !soft_rst) |=> (rx_valid && $stable(rx_data))); // R13
  AST_RX_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> !$past(rx_discard)); // R5
  AST_CS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_manual |-> ($countones(cs_o ^ {NUM_CS{~cs_pol}}) <= 1)); // R9
  AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !(enable && master) && !busy) |=> !busy); // R11
endmodule

bind spi_xfer_engine spi_xfer_engine_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .soft_rst   (cfg_soft_rst),
  .enable     (cfg_enable),
  .master     (cfg_master),
  .cpol       (cfg_cpol),
  .cs_pol     (cfg_cs_pol),
  .cs_manual  (cfg_cs_manual),
  .rx_discard (cfg_rx_discard),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .tx_ready   (tx_ready),
  .rx_valid   (rx_valid),
  .rx_ready   (rx_ready),
  .rx_data    (rx_data),
  .sck        (sck),
  .cs_o       (cs_o)
);

// File: tb/spi_xfer_engine_tb.sv
`timescale 1ns/1ps
module spi_xfer_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_enable = 1'b1, cfg_master = 1'b1, cfg_soft_rst = 1'b0;
  logic        cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb_first = 1'b0;
  logic        cfg_cs_pol = 1'b0, cfg_cs_manual = 1'b0, cfg_cs_level = 1'b0;
  logic [1:0]  cfg_cs_sel = 2'd0;
  logic        cfg_rx_discard = 1'b0;
  logic [23:0] burst_len = '0, tx_len = '0;
  logic        start = 1'b0;
  logic        busy, done, sck_tick = 1'b0, tick_on = 1'b1;
  logic        tx_valid, tx_ready;
  logic [7:0]  tx_data;
  logic        rx_valid, rx_ready = 1'b1;
  logic [7:0]  rx_data;
  logic        sck, mosi, miso;
  logic [3:0]  cs_o;

  int checks = 0, errors = 0;

  logic [7:0] tx_mem [0:15];
  logic [7:0] rx_mem [0:15];
  logic [7:0] wire_mem [0:63];
  int tx_ptr = 0, tx_n = 0, rn = 0, wn = 0, done_cnt = 0, edge_cnt = 0, cap_n = 0;
  logic tx_en = 1'b1, clr = 1'b0, sck_prev = 1'b0;
  logic [7:0] cap = '0;

  always #4 clk = ~clk;

  assign tx_valid = tx_en && (tx_ptr < tx_n);
  assign tx_data  = tx_mem[tx_ptr[3:0]];
  assign miso     = ~mosi;

  spi_xfer_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_master(cfg_master),
    .cfg_soft_rst(cfg_soft_rst), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_lsb_first(cfg_lsb_first), .cfg_cs_pol(cfg_cs_pol), .cfg_cs_sel(cfg_cs_sel),
    .cfg_cs_manual(cfg_cs_manual), .cfg_cs_level(cfg_cs_level),
    .cfg_rx_discard(cfg_rx_discard), .burst_len(burst_len), .tx_len(tx_len),
    .start(start), .busy(busy), .done(done), .sck_tick(sck_tick),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .sck(sck), .mosi(mosi), .miso(miso), .cs_o(cs_o)
  );

  always @(posedge clk) begin
    if (tick_on) sck_tick <= ~sck_tick;
    else         sck_tick <= 1'b0;
    if (done) done_cnt <= done_cnt + 1;
    if (clr) begin
      tx_ptr <= 0;
      rn     <= 0;
    end else begin
      if (tx_valid && tx_ready) tx_ptr <= tx_ptr + 1;
      if (rx_valid && rx_ready) begin
        rx_mem[rn[3:0]] <= rx_data;
        rn <= rn + 1;
      end
    end
  end

  // Wire monitor: records MOSI at each capture edge, counts SCK transitions in a burst.
  always @(negedge clk) begin
    if (busy && (sck !== sck_prev)) begin
      edge_cnt = edge_cnt + 1;
      if ((sck != cfg_cpol) ^ cfg_cpha) begin
        cap   = {cap[6:0], mosi};
        cap_n = cap_n + 1;
        if (cap_n == 8) begin
          wire_mem[wn[5:0]] = cap;
          wn    = wn + 1;
          cap_n = 0;
        end
      end
    end
    sck_prev = sck;
  end

  function automatic logic [7:0] bitrev(input logic [7:0] v);
    for (int i = 0; i < 8; i++) bitrev[i] = v[7-i];
  endfunction

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(input int base);
    for (int k = 0; k < 4000 && done_cnt == base; k++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic prep(input int bl, input int tl, input logic [7:0] seed);
    @(negedge clk);
    for (int i = 0; i < 16; i++) tx_mem[i] = seed + 8'(i * 37);
    burst_len = 24'(bl); tx_len = 24'(tl); tx_n = tl;
    clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic run_xfer(input int bl, input int tl, input logic pol, input logic pha,
                          input logic lsb, input logic disc, input logic [7:0] seed, input string tag);
    int dbase, wbase, ebase, nt;
    logic [7:0] sent, expw;
    @(negedge clk);
    cfg_cpol = pol; cfg_cpha = pha; cfg_lsb_first = lsb; cfg_rx_discard = disc; tx_en = 1'b1;
    prep(bl, tl, seed);
    dbase = done_cnt; wbase = wn; ebase = edge_cnt;
    pulse_start();
    wait_done(dbase);
    nt = (tl < bl) ? tl : bl;
    check(done_cnt == dbase + 1, {tag, " R8 one done"}, done_cnt - dbase, 1);
    check(!busy, {tag, " R8 idle after done"}, busy, 0);
    check(edge_cnt - ebase == 16 * bl, {tag, " R2 sck transitions"}, edge_cnt - ebase, 16 * bl);
    check(tx_ptr == nt, {tag, " R4 tx handshakes"}, tx_ptr, nt);
    check(rn == (disc ? 0 : bl), {tag, " R5 rx count"}, rn, disc ? 0 : bl);
    for (int i = 0; i < bl; i++) begin
      sent = (i < nt) ? tx_mem[i] : 8'h00;
      expw = lsb ? bitrev(sent) : sent;
      check(wire_mem[(wbase + i) % 64] == expw, {tag, " R3 mosi order"}, wire_mem[(wbase + i) % 64], expw);
      if (!disc && i < 16)
        check(rx_mem[i] == ~sent, {tag, " R2 rx byte"}, rx_mem[i], ~sent);
    end
    check(sck == pol, {tag, " R1 sck rest"}, sck, pol);
  endtask

  task automatic t_reset();
    check(sck == 1'b0, "R1 reset sck", sck, 0);
    check(!busy && !done, "R8 reset idle", {busy, done}, 0);
    check(cs_o == 4'hF, "R9 reset cs", cs_o, 4'hF);
    check(!rx_valid && !tx_ready, "R13 reset streams", {rx_valid, tx_ready}, 0);
  endtask

  task automatic t_idle_cpol();
    @(negedge clk); cfg_cpol = 1'b1;
    repeat (4) @(negedge clk);
    check(sck == 1'b1, "R1 idle sck follows cpol", sck, 1);
    cfg_cpol = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_tx_stall();
    int dbase, ebase;
    cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_lsb_first = 1'b0; cfg_rx_discard = 1'b0;
    cfg_cs_sel = 2'd2; cfg_cs_pol = 1'b1;
    tx_en = 1'b0;
    prep(1, 1, 8'h5C);
    dbase = done_cnt; ebase = edge_cnt;
    pulse_start();
    repeat (60) @(negedge clk);
    check(busy && tx_ready, "R6 stalled busy and ready", {busy, tx_ready}, 3);
    check(edge_cnt == ebase, "R6 no sck edges", edge_cnt - ebase, 0);
    check(sck == 1'b0, "R6 sck at rest", sck, 0);
    check(cs_o == 4'b0100, "R9 auto cs active high", cs_o, 4'b0100);
    tx_en = 1'b1;
    wait_done(dbase);
    check(done_cnt == dbase + 1, "R6 completes after data", done_cnt - dbase, 1);
    check(wire_mem[(wn - 1) % 64] == 8'h5C, "R6 byte sent", wire_mem[(wn - 1) % 64], 8'h5C);
    check(cs_o == 4'b0000, "R9 cs released", cs_o, 4'b0000);
    cfg_cs_sel = 2'd0; cfg_cs_pol = 1'b0;
  endtask

  task automatic t_rx_backpressure();
    int dbase, ebase;
    logic [7:0] held;
    cfg_cpol = 1'b0; cfg_cpha = 1'b1; cfg_lsb_first = 1'b0; cfg_rx_discard = 1'b0; tx_en = 1'b1;
    rx_ready = 1'b0;
    prep(2, 2, 8'h39);
    dbase = done_cnt; ebase = edge_cnt;
    pulse_start();
    repeat (150) @(negedge clk);
    check(edge_cnt - ebase == 16, "R7 only first byte shifted", edge_cnt - ebase, 16);
    check(busy && rx_valid, "R7 waiting on rx", {busy, rx_valid}, 3);
    held = rx_data;
    repeat (5) @(negedge clk);
    check(rx_data == held && rx_valid, "R13 rx held", rx_data, held);
    check(rx_data == ~tx_mem[0], "R13 rx first byte", rx_data, ~tx_mem[0]);
    rx_ready = 1'b1;
    wait_done(dbase);
    check(rn == 2 && done_cnt == dbase + 1, "R7 resumes", rn, 2);
  endtask

  task automatic t_manual_cs();
    @(negedge clk);
    cfg_cs_manual = 1'b1; cfg_cs_sel = 2'd1; cfg_cs_pol = 1'b0; cfg_cs_level = 1'b0;
    @(negedge clk);
    check(cs_o == 4'b1101, "R10 manual low", cs_o, 4'b1101);
    cfg_cs_pol = 1'b1; cfg_cs_level = 1'b1;
    @(negedge clk);
    check(cs_o == 4'b0010, "R10 manual high", cs_o, 4'b0010);
    cfg_cs_manual = 1'b0; cfg_cs_sel = 2'd0; cfg_cs_pol = 1'b0; cfg_cs_level = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_disabled();
    int dbase, ebase;
    prep(1, 1, 8'h11);
    dbase = done_cnt; ebase = edge_cnt;
    cfg_enable = 1'b0;
    pulse_start();
    repeat (40) @(negedge clk);
    check(!busy && done_cnt == dbase, "R11 start ignored when disabled", busy, 0);
    cfg_enable = 1'b1; cfg_master = 1'b0;
    pulse_start();
    repeat (40) @(negedge clk);
    check(!busy && done_cnt == dbase && edge_cnt == ebase, "R11 start ignored when not master", busy, 0);
    cfg_master = 1'b1;
  endtask

  task automatic t_soft_reset();
    int dbase;
    tx_en = 1'b0;
    prep(2, 2, 8'h77);
    dbase = done_cnt;
    pulse_start();
    repeat (10) @(negedge clk);
    check(busy, "R12 burst pending", busy, 1);
    cfg_soft_rst = 1'b1;
    @(negedge clk); cfg_soft_rst = 1'b0;
    repeat (3) @(negedge clk);
    check(!busy && done_cnt == dbase, "R12 aborted silently", {busy, 1'b0}, 0);
    check(cs_o == 4'hF, "R12 cs inactive", cs_o, 4'hF);
    tx_en = 1'b1;
    run_xfer(1, 1, 1'b0, 1'b0, 1'b0, 1'b0, 8'hC3, "R12 restart");
  endtask

  task automatic t_zero_burst();
    int dbase, ebase;
    prep(0, 0, 8'h00);
    dbase = done_cnt; ebase = edge_cnt;
    pulse_start();
    repeat (4) @(negedge clk);
    check(done_cnt == dbase + 1, "R8 zero burst done", done_cnt - dbase, 1);
    check(edge_cnt == ebase && !busy, "R8 zero burst no sck", edge_cnt - ebase, 0);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_cpol();
    run_xfer(3, 3, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA1, "R2 mode0");
    run_xfer(2, 2, 1'b1, 1'b1, 1'b1, 1'b0, 8'h4E, "R3 mode3 lsb");
    run_xfer(2, 2, 1'b0, 1'b1, 1'b0, 1'b0, 8'h96, "R2 mode1");
    run_xfer(2, 2, 1'b1, 1'b0, 1'b1, 1'b0, 8'h2B, "R3 mode2 lsb");
    run_xfer(4, 2, 1'b0, 1'b0, 1'b0, 1'b0, 8'hD4, "R4 dummy tail");
    run_xfer(1, 3, 1'b0, 1'b0, 1'b0, 1'b0, 8'h68, "R4 tx beyond burst");
    run_xfer(2, 2, 1'b0, 1'b0, 1'b0, 1'b1, 8'hB7, "R5 discard");
    cfg_rx_discard = 1'b0;
    t_tx_stall();
    t_rx_backpressure();
    t_manual_cs();
    t_disabled();
    t_soft_reset();
    t_zero_burst();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule